// File: doc/BRIEF.md
# General-Purpose Pin Controller with Edge and Level Interrupts

This block manages sixteen general-purpose pins. Each pin is an input or an output, chosen by its own direction bit. The output values live in one register. Software changes that register through separate write addresses that set, clear or invert only the bits written as one, or through a plain load of the whole word. Any group of pins can therefore change in a single write while the other pins keep their values. Input pins pass through a two-flop synchronizer. The block reports the effective level of every pin: the driven value for outputs and the synchronized value for inputs.

Every pin can act as an interrupt source. Its enable bit is changed through a mask-set address and a mask-clear address. A per-pin sense bit makes the source level-sensitive or edge-sensitive. For edge pins, a second bit picks rising edges only or both edges. Edge events are held until software writes a one to the matching bit of the interrupt-clear address. A level source stays active only while its pin is high. Because edge detection runs on the effective level, a software write to an output pin can also raise an interrupt. A single interrupt line is the OR of all active sources.

Register access is a write port that takes effect on the next clock edge, and a read port that returns data one cycle after the request with a valid flag.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero and `pin_oe`, `pin_o` and `irq` are zero.
- R2: A write to address 0 loads the direction word (1 = output). `pin_oe` equals it from the next cycle on, and a read of address 0 returns it.
- R3: A write to address 1 loads the full output word. `pin_o` shows it on the next cycle, and a read of address 1 returns it.
- R4: A write to address 2 forces high every output bit written as 1 and leaves the other bits unchanged.
- R5: A write to address 3 forces low every output bit written as 1 and leaves the other bits unchanged.
- R6: A write to address 4 inverts every output bit written as 1 and leaves the other bits unchanged.
- R7: Address 5 sets and address 6 clears interrupt-enable bits written as 1. A read of address 5 returns the enables. A pin whose enable is 0 never contributes to the interrupt status.
- R8: A read of address 10 returns the pin levels: the output value for pins with direction 1, and the input sampled through two flops for pins with direction 0. External input on output pins has no effect.
- R9: For an enabled pin whose sense bit (address 7) is 0, the status bit (read at address 11) is 1 exactly while the pin level is high, and nothing is held after the level falls.
- R10: For an enabled pin with sense bit 1 and both-edges bit (address 8) 0, a low-to-high change latches its status bit, and a high-to-low change does not.
- R11: For an enabled pin with sense bit 1 and both-edges bit 1, either change of level latches its status bit.
- R12: Writing 1s to address 9 clears the matching latched bits. When a clear and a new edge reach the same bit in the same cycle, the clear wins.
- R13: A software write that makes an enabled, edge-sensitive output pin rise latches its status bit just as an input edge would.
- R14: `irq` is 1 exactly when at least one interrupt status bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data, one bit per pin |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, valid one cycle after the request |
| rd_valid | output | 1 | High in the cycle that `rd_data` holds a response |
| pin_i | input | 16 | Raw pin inputs |
| pin_o | output | 16 | Output value per pin |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the collision where an interrupt-clear write lands in the same cycle that a synchronized edge would latch. An edge appears three clock edges after the pin changes, so the bench starts the clear write exactly one cycle after it changes the pin and then checks that the bit reads back as zero. Another case needs care: an output pin that raises its own interrupt. The bench falls and then rises such a pin through the clear and set addresses and expects a latch only on the rise.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;

    localparam int NPINS  = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 4'd0,
        REG_OUT   = 4'd1,
        REG_OSET  = 4'd2,
        REG_OCLR  = 4'd3,
        REG_OTGL  = 4'd4,
        REG_MSET  = 4'd5,
        REG_MCLR  = 4'd6,
        REG_SENSE = 4'd7,
        REG_BOTH  = 4'd8,
        REG_ICLR  = 4'd9,
        REG_LVL   = 4'd10,
        REG_ISTAT = 4'd11
    } reg_addr_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_TGL
    } bit_op_e;

    function automatic logic apply_op(input logic cur, input logic din, input bit_op_e op);
        case (op)
            OP_LOAD: return din;
            OP_SET:  return cur | din;
            OP_CLR:  return cur & ~din;
            OP_TGL:  return cur ^ din;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_bitop_reg.sv
module gpio_bitop_reg
    import gpio_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  bit_op_e      op,
    input  logic [W-1:0] data,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i] = apply_op(q[i], data[i], op);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R4
    set_only_touches_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET) |=> (q == ($past(q) | $past(data))));

    // R5
    clr_only_touches_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR) |=> (q == ($past(q) & ~$past(data))));

    // R6
    tgl_only_touches_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TGL) |=> (q == ($past(q) ^ $past(data))));

    // R3
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> $stable(q));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] istat
);
    logic [W-1:0] prev_q, pend_q, pend_d;
    logic [W-1:0] rise, fall, hit, clr_bits;

    always_comb begin
        rise     = lvl & ~prev_q;
        fall     = ~lvl & prev_q;
        hit      = mask & sense & (rise | (both & fall));
        clr_bits = clr_en ? clr_data : '0;
        pend_d   = (pend_q | hit) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lvl;
            pend_q <= pend_d;
        end
    end

    assign istat = pend_q | (mask & ~sense & lvl);

    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((pend_q & $past(clr_data)) == '0));

    // R7
    masked_never_latches_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(mask)) == '0));

    // R10
    rising_only_ignores_fall_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(both) & ~$past(lvl)) == '0));
endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
    import gpio_flag_pkg::*;
#(
    parameter int PINS     = NPINS,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PINS-1:0]   wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PINS-1:0]   rd_data,
    output logic              rd_valid,
    input  logic [PINS-1:0]   pin_i,
    output logic [PINS-1:0]   pin_o,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    reg_addr_e       wr_sel, rd_sel;
    bit_op_e         out_op, mask_op;
    logic [PINS-1:0] dir_q, sense_q, both_q, out_q, mask_q;
    logic [PINS-1:0] pin_s, lvl, istat, rd_mux;
    logic            iclr_en;

    assign wr_sel = reg_addr_e'(wr_addr);
    assign rd_sel = reg_addr_e'(rd_addr);

    always_comb begin
        out_op  = OP_NONE;
        mask_op = OP_NONE;
        if (wr_en) begin
            case (wr_sel)
                REG_OUT:  out_op  = OP_LOAD;
                REG_OSET: out_op  = OP_SET;
                REG_OCLR: out_op  = OP_CLR;
                REG_OTGL: out_op  = OP_TGL;
                REG_MSET: mask_op = OP_SET;
                REG_MCLR: mask_op = OP_CLR;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == REG_DIR)   dir_q   <= wr_data;
            if (wr_sel == REG_SENSE) sense_q <= wr_data;
            if (wr_sel == REG_BOTH)  both_q  <= wr_data;
        end
    end

    gpio_bitop_reg #(.W(PINS)) u_out (
        .clk(clk), .rst(rst), .op(out_op), .data(wr_data), .q(out_q)
    );

    gpio_bitop_reg #(.W(PINS)) u_mask (
        .clk(clk), .rst(rst), .op(mask_op), .data(wr_data), .q(mask_q)
    );

    gpio_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .din(pin_i), .dout(pin_s)
    );

    assign lvl     = (out_q & dir_q) | (pin_s & ~dir_q);
    assign iclr_en = wr_en && (wr_sel == REG_ICLR);

    gpio_irq #(.W(PINS)) u_irq (
        .clk(clk), .rst(rst), .lvl(lvl), .mask(mask_q), .sense(sense_q),
        .both(both_q), .clr_en(iclr_en), .clr_data(wr_data), .istat(istat)
    );

    always_comb begin
        case (rd_sel)
            REG_DIR:   rd_mux = dir_q;
            REG_OUT:   rd_mux = out_q;
            REG_MSET:  rd_mux = mask_q;
            REG_SENSE: rd_mux = sense_q;
            REG_BOTH:  rd_mux = both_q;
            REG_LVL:   rd_mux = lvl;
            REG_ISTAT: rd_mux = istat;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    assign pin_o  = out_q;
    assign pin_oe = dir_q;
    assign irq    = |istat;

    // R2
    dir_write_reaches_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_DIR) |=> (pin_oe == $past(wr_data)));

    // R14
    irq_idle_when_no_source_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0 && $past(mask_q) == '0 && $past(iclr_en) && $past(wr_data) == '1) |-> !irq);
endmodule

// File: tb/gpio_flag_ctrl_test.sv
module gpio_flag_ctrl_test;
    import gpio_flag_pkg::*;

    localparam int W = NPINS;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [W-1:0]      wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [W-1:0]      rd_data;
    logic              rd_valid;
    logic [W-1:0]      pin_i, pin_o, pin_oe;
    logic              irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_flag_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops expected read responses as the design produces them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected response actual=%h expected=none", rd_data);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input reg_addr_e a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, input logic [W-1:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0; pin_i = '0;
        wait_cyc(4);
        rst = 1'b0;

        // R1 reset state
        chk(pin_oe, '0, "R1 pin_oe");
        chk(pin_o, '0, "R1 pin_o");
        chk({15'd0, irq}, '0, "R1 irq");
        rd(REG_DIR, 16'h0000, "R1 dir");
        rd(REG_OUT, 16'h0000, "R1 out");
        rd(REG_MSET, 16'h0000, "R1 mask");
        rd(REG_ISTAT, 16'h0000, "R1 istat");

        // R2 direction
        wr(REG_DIR, 16'h00FF);
        chk(pin_oe, 16'h00FF, "R2 pin_oe");
        rd(REG_DIR, 16'h00FF, "R2 dir readback");

        // R3 direct load
        wr(REG_OUT, 16'h1234);
        chk(pin_o, 16'h1234, "R3 pin_o");
        rd(REG_OUT, 16'h1234, "R3 out readback");

        // R4 / R5 / R6 write-one-to-modify
        wr(REG_OSET, 16'h00F0);
        chk(pin_o, 16'h12F4, "R4 set");
        wr(REG_OCLR, 16'h0204);
        chk(pin_o, 16'h10F0, "R5 clear");
        wr(REG_OTGL, 16'h00FF);
        chk(pin_o, 16'h100F, "R6 toggle");
        rd(REG_OUT, 16'h100F, "R6 out readback");

        // R8 pin levels
        pin_i = 16'hAB00;
        wait_cyc(2);
        rd(REG_LVL, 16'hAB0F, "R8 level mix");
        pin_i = 16'hABFF;
        wait_cyc(2);
        rd(REG_LVL, 16'hAB0F, "R8 input on output pins ignored");

        // R7 mask set/clear
        wr(REG_MSET, 16'hF000);
        wr(REG_MCLR, 16'h3000);
        rd(REG_MSET, 16'hC000, "R7 mask");

        // R9 level sensitivity (bit13 high but masked: R7)
        rd(REG_ISTAT, 16'h8000, "R9 level active");
        chk({15'd0, irq}, 16'h0001, "R14 irq on level");
        pin_i = 16'h2BFF;
        wait_cyc(2);
        rd(REG_ISTAT, 16'h0000, "R9 level released");
        chk({15'd0, irq}, 16'h0000, "R14 irq off");

        // edge setup
        wr(REG_MCLR, 16'hFFFF);
        pin_i = 16'h0000;
        wait_cyc(4);
        wr(REG_SENSE, 16'h0300);
        wr(REG_BOTH, 16'h0200);
        wr(REG_MSET, 16'h0300);
        wr(REG_ICLR, 16'hFFFF);
        rd(REG_ISTAT, 16'h0000, "R12 clean start");

        // R10 / R11 rising
        pin_i = 16'h0300;
        wait_cyc(3);
        rd(REG_ISTAT, 16'h0300, "R10 R11 rising latched");
        chk({15'd0, irq}, 16'h0001, "R14 irq on edge");
        wr(REG_ICLR, 16'hFFFF);
        rd(REG_ISTAT, 16'h0000, "R12 cleared");

        // falling: only both-edge pin latches
        pin_i = 16'h0000;
        wait_cyc(3);
        rd(REG_ISTAT, 16'h0200, "R10 R11 falling");
        wr(REG_ICLR, 16'h0200);
        rd(REG_ISTAT, 16'h0000, "R12 partial clear");
        chk({15'd0, irq}, 16'h0000, "R14 irq cleared");

        // R12 clear collides with new edge
        pin_i = 16'h0100;
        wait_cyc(1);
        wr(REG_ICLR, 16'h0100);
        wait_cyc(2);
        rd(REG_ISTAT, 16'h0000, "R12 clear wins over edge");

        // R13 output pin raises interrupt by software write
        wr(REG_SENSE, 16'h0301);
        wr(REG_MSET, 16'h0001);
        wr(REG_ICLR, 16'hFFFF);
        wr(REG_OCLR, 16'h0001);
        wait_cyc(1);
        rd(REG_ISTAT, 16'h0000, "R13 falling output no latch");
        wr(REG_OSET, 16'h0001);
        wait_cyc(1);
        rd(REG_ISTAT, 16'h0001, "R13 rising output latched");
        chk({15'd0, irq}, 16'h0001, "R14 irq from output");

        wait_cyc(3);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule